// File: doc/BRIEF.md
# Indirect Two-Device Peripheral Bus Bridge

This block lets a 32-bit memory-mapped host reach two 8-bit peripheral chips over a shared parallel bus. Both chips hang off the same bus with their own select lines. The host sees a single command/status word in its memory window. One write to that word starts one bus cycle. The cycle targets one of the two chips and either that chip's address-latch register or its data register, and it runs as a read or a write. The host then polls a pending flag in the same word. When a read cycle finishes, the byte it captured appears in the low byte of the word.

Each access to a register inside a peripheral takes two such cycles. The first writes the internal register offset into the chip's address latch. The second reads or writes the chip's data register. The host waits for pending to clear after each step. On the second chip, the second channel sits 0x40 above the first. Its FIFO is therefore at offset 0x5F, and the first channel's FIFO is at 0x1F. The first chip's FIFO is at offset 0x1E.

Every bus cycle has the same shape. There is one setup clock with selects, register select and direction driven. Then the strobe is held for a parameterised number of clocks, and read data is sampled on the last of them. One hold clock follows, and after it the bridge returns to idle.

Top module: `pbus_bridge`

## Requirements
- R1: After reset the pending flag reads 0, the captured byte reads 0x00, and pb_sel, pb_stb and pb_doe are all 0.
- R2: The command/status word responds only at byte offset 0x200. A host write to any other offset starts no cycle, and a read of any other offset returns 0.
- R3: Command field encoding: bit 23 = 1 selects a write cycle (pb_wr = 1) and 0 a read cycle; bit 20 = 0 targets the first peripheral (pb_sel = 2'b01) and 1 the second (pb_sel = 2'b10); bit 16 = 0 targets the address-latch register (pb_reg = 0) and 1 the data register (pb_reg = 1).
- R4: Bit 25 reads 1 from the clock after a command is accepted until the cycle completes. It stays 1 for exactly STROBE_CYC + 2 clocks.
- R5: A host write to the word while bit 25 is 1 is ignored. The cycle in progress, its bus lines and its latched command fields stay unchanged, and no further cycle follows.
- R6: A cycle has one setup clock with selects driven and pb_stb = 0, then pb_stb = 1 for STROBE_CYC clocks, then one hold clock with pb_stb = 0 and selects still driven. Pending clears on the next edge.
- R7: During a write cycle, pb_doe = 1 and pb_dout carries bits 7:0 of the command for the whole cycle.
- R8: A read cycle samples pb_din on the last strobe clock and returns that byte in bits 7:0. Write cycles leave the captured byte unchanged.
- R9: A read of the word returns the pending flag in bit 25, the last accepted write/read, group and register bits in bits 23, 20 and 16, and the captured byte in bits 7:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_en | input | 1 | Host access valid for this clock |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | ADDR_W | Host byte offset within the bridge window |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data (combinational on hst_addr) |
| pb_sel | output | 2 | Per-peripheral select, one-hot while a cycle runs |
| pb_reg | output | 1 | Register select: 0 address latch, 1 data |
| pb_wr | output | 1 | Cycle direction: 1 write, 0 read |
| pb_stb | output | 1 | Transfer strobe |
| pb_dout | output | 8 | Byte driven to the peripherals on writes |
| pb_doe | output | 1 | Output enable for pb_dout |
| pb_din | input | 8 | Byte returned by the selected peripheral |

## Verification
The assertions assume a host that follows the polling protocol. A cycle is started only with a full word write to offset 0x200, and the peripheral side only supplies pb_din. They also assume reset is held for at least one clock before any access. The stimulus applies every host access half a clock away from the active edge and deasserts hst_en after one clock. It waits for the pending bit to clear between normal commands. Only the directed test for R5 writes on purpose while a cycle is in flight. The peripheral model in the bench drives a valid byte only on the last strobe clock and a filler byte at all other times, so a sample taken on the wrong clock shows up as a data mismatch.

// File: rtl/pbus_bridge.sv
module pbus_bridge #(
  parameter int ADDR_W     = 12,
  parameter int CMD_OFFSET = 'h200,
  parameter int STROBE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_en,
  input  logic              hst_we,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic [1:0]        pb_sel,
  output logic              pb_reg,
  output logic              pb_wr,
  output logic              pb_stb,
  output logic [7:0]        pb_dout,
  output logic              pb_doe,
  input  logic [7:0]        pb_din
);

  localparam int PEND_BIT = 25;
  localparam int WR_BIT   = 23;
  localparam int GRP_BIT  = 20;
  localparam int REG_BIT  = 16;
  localparam int CNT_W    = $clog2(STROBE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STB, S_HOLD} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic            cmd_wr, cmd_grp, cmd_reg;
  logic [7:0]      out_byte, rd_byte;

  wire hit     = (hst_addr == ADDR_W'(CMD_OFFSET));
  wire pending = (st != S_IDLE);
  wire accept  = hst_en && hst_we && hit && !pending;

  logic unused_wdata;
  assign unused_wdata = ^{hst_wdata[31:24], hst_wdata[22:21], hst_wdata[19:17], hst_wdata[15:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cmd_wr   <= 1'b0;
      cmd_grp  <= 1'b0;
      cmd_reg  <= 1'b0;
      out_byte <= 8'h00;
      rd_byte  <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          cmd_wr   <= hst_wdata[WR_BIT];
          cmd_grp  <= hst_wdata[GRP_BIT];
          cmd_reg  <= hst_wdata[REG_BIT];
          out_byte <= hst_wdata[7:0];
          cnt      <= '0;
          st       <= S_SETUP;
        end
        S_SETUP: st <= S_STB;
        S_STB: begin
          if (cnt == CNT_LAST) begin
            if (!cmd_wr) rd_byte <= pb_din;
            st <= S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pb_sel  = pending ? (cmd_grp ? 2'b10 : 2'b01) : 2'b00;
  assign pb_reg  = pending & cmd_reg;
  assign pb_wr   = pending & cmd_wr;
  assign pb_stb  = (st == S_STB);
  assign pb_doe  = pending & cmd_wr;
  assign pb_dout = pb_doe ? out_byte : 8'h00;

  always_comb begin
    hst_rdata = 32'h0;
    if (hit) begin
      hst_rdata[PEND_BIT] = pending;
      hst_rdata[WR_BIT]   = cmd_wr;
      hst_rdata[GRP_BIT]  = cmd_grp;
      hst_rdata[REG_BIT]  = cmd_reg;
      hst_rdata[7:0]      = rd_byte;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !pending |-> (pb_sel == 2'b00) && !pb_stb && !pb_doe);

  assert_one_select_R3: assert property (@(posedge clk) disable iff (rst)
    pending |-> $countones(pb_sel) == 1);

  assert_start_setup_R4: assert property (@(posedge clk) disable iff (rst)
    (hst_en && hst_we && hit && !pending) |=> pending && !pb_stb);

  assert_busy_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (pending && $past(pending)) |-> $stable(pb_sel) && $stable(pb_reg) && $stable(pb_wr) && $stable(pb_dout));

  assert_hold_after_stb_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pb_stb) |-> pending);

  assert_release_after_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> !$past(pb_stb));

  assert_wr_drives_R7: assert property (@(posedge clk) disable iff (rst)
    pb_wr |-> pb_doe);

endmodule

// File: tb/pbus_bridge_tb.sv
module pbus_bridge_tb;
  localparam int NSTB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_en = 1'b0, hst_we = 1'b0;
  logic [11:0] hst_addr = 12'h200;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic [1:0]  pb_sel;
  logic        pb_reg, pb_wr, pb_stb, pb_doe;
  logic [7:0]  pb_dout, pb_din;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pbus_bridge #(.ADDR_W(12), .CMD_OFFSET('h200), .STROBE_CYC(NSTB)) u_dut (
    .clk, .rst, .hst_en, .hst_we, .hst_addr, .hst_wdata, .hst_rdata,
    .pb_sel, .pb_reg, .pb_wr, .pb_stb, .pb_dout, .pb_doe, .pb_din);

  // peripheral model: acts only on the last strobe clock
  int         stb_cnt = 0;
  logic [6:0] lat [0:1];
  logic [7:0] pmem [0:255];
  initial begin
    lat[0] = '0; lat[1] = '0;
    for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
  end
  always @(posedge clk) stb_cnt <= pb_stb ? stb_cnt + 1 : 0;
  always @(posedge clk) if (pb_stb && stb_cnt == NSTB-1 && pb_wr) begin
    if (!pb_reg) lat[pb_sel[1]] <= pb_dout[6:0];
    else pmem[{pb_sel[1], lat[pb_sel[1]]}] <= pb_dout;
  end
  assign pb_din = (pb_stb && stb_cnt == NSTB-1 && !pb_wr && pb_reg) ?
                  pmem[{pb_sel[1], lat[pb_sel[1]]}] : 8'hEE;

  // {grp, offset[6:0], byte}
  localparam logic [15:0] VEC [6] = '{16'h1EA5, 16'h0C3C, 16'h9F5A, 16'hDFC3, 16'h8001, 16'h3F7E};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(bit wr, bit grp, bit rg, logic [7:0] b);
    return {6'b0, 1'b0, 1'b0, wr, 2'b0, grp, 3'b0, rg, 8'b0, b};
  endfunction

  task automatic host_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    hst_en = 1; hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_en = 0; hst_we = 0; hst_addr = 12'h200;
  endtask

  task automatic host_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #1 d = hst_rdata;
    hst_addr = 12'h200;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 50; i++) begin
      host_read(12'h200, r);
      if (!r[25]) return;
    end
  endtask

  task automatic cmd(bit wr, bit grp, bit rg, logic [7:0] b);
    host_write(12'h200, cmdw(wr, grp, rg, b));
    wait_idle();
  endtask

  task automatic pacc_write(bit grp, logic [6:0] off, logic [7:0] b);
    cmd(1, grp, 0, {1'b0, off});
    cmd(1, grp, 1, b);
  endtask

  task automatic pacc_read(bit grp, logic [6:0] off, output logic [7:0] b);
    logic [31:0] r;
    cmd(1, grp, 0, {1'b0, off});
    cmd(0, grp, 1, 8'h00);
    host_read(12'h200, r);
    b = r[7:0];
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    int stb_seen, pend_seen, first_stb;
    bit sel_ok, drv_ok;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    host_read(12'h200, r);
    check("R1 word", r, 32'h0);
    check("R1 bus", {pb_sel, pb_stb, pb_doe}, 4'b0000);

    // R2 other offsets
    host_write(12'h204, cmdw(1, 1, 0, 8'h12));
    host_read(12'h200, r);
    check("R2 no start", r[25], 1'b0);
    host_read(12'h204, r);
    check("R2 read elsewhere", r, 32'h0);

    // R3 R4 R6 R7 cycle shape
    @(negedge clk);
    hst_en = 1; hst_we = 1; hst_addr = 12'h200; hst_wdata = cmdw(1, 1, 0, 8'h5F);
    @(posedge clk);
    stb_seen = 0; pend_seen = 0; first_stb = 0; sel_ok = 1; drv_ok = 1;
    for (int k = 1; k <= NSTB + 3; k++) begin
      @(negedge clk);
      if (k == 1) begin hst_en = 0; hst_we = 0; end
      #1;
      if (hst_rdata[25]) begin
        pend_seen++;
        if (pb_sel != 2'b10 || pb_reg != 1'b0 || pb_wr != 1'b1) sel_ok = 0;
        if (!pb_doe || pb_dout != 8'h5F) drv_ok = 0;
      end
      if (pb_stb) begin
        stb_seen++;
        if (first_stb == 0) first_stb = k;
      end
      if (k == NSTB + 2) check("R6 hold clock", {pb_stb, hst_rdata[25], pb_sel}, {1'b0, 1'b1, 2'b10});
      if (k == NSTB + 3) check("R6 idle after hold", {hst_rdata[25], pb_sel, pb_doe}, 4'b0000);
    end
    check("R4 pending length", pend_seen, NSTB + 2);
    check("R6 strobe length", stb_seen, NSTB);
    check("R6 setup clock", first_stb, 2);
    check("R3 lines", sel_ok, 1'b1);
    check("R7 drive", drv_ok, 1'b1);

    // R8 R3 table walk: write all, then read all
    foreach (VEC[i]) pacc_write(VEC[i][15], VEC[i][14:8], VEC[i][7:0]);
    foreach (VEC[i]) begin
      pacc_read(VEC[i][15], VEC[i][14:8], b);
      check("R8 readback", b, VEC[i][7:0]);
    end

    // R8 write cycle keeps captured byte; R9 layout
    pacc_read(1'b1, 7'h5F, b);
    pacc_write(1'b0, 7'h20, 8'h99);
    host_read(12'h200, r);
    check("R8 write keeps byte", r[7:0], 8'hC3);
    check("R9 layout", r, cmdw(1, 0, 1, 8'hC3));

    // R5 write while pending ignored
    cmd(1, 0, 0, 8'h10);
    host_write(12'h200, cmdw(1, 0, 1, 8'h77));
    host_write(12'h200, cmdw(1, 1, 0, 8'h33));
    check("R5 lines frozen", {pb_sel, pb_reg, pb_wr, pb_dout}, {2'b01, 1'b1, 1'b1, 8'h77});
    wait_idle();
    host_read(12'h200, r);
    check("R5 fields kept", r, cmdw(1, 0, 1, 8'hC3));
    repeat (NSTB + 4) @(negedge clk);
    #1 check("R5 no extra cycle", {hst_rdata[25], pb_sel}, 3'b000);
    pacc_read(1'b0, 7'h10, b);
    check("R5 first write landed", b, 8'h77);
    pacc_read(1'b1, 7'h1F, b);
    check("R5 group1 untouched", b, 8'h5A);

    // R9 read of another offset after activity
    host_read(12'h3FC, r);
    check("R9 other offset zero", r, 32'h0);

    done = 1;
    finish_run();
  end
endmodule